// File: doc/BRIEF.md
# Status Register Write-Enable Latch

This block holds an 8-bit volatile status byte that decides whether writes elsewhere in the device may proceed. It holds two write-protect latches. The general latch opens the storage array and is needed for any protected write. The register latch also opens the control registers. Next to them sit read-only bits: one shows operation from the backup supply, two are alarm flags, and one is a power-fail flag that stays set until the first real control-register write.

The serial front end presents each data byte as a one-cycle write request with an address. The block decodes the address into three regions: the status byte itself, the control-register window, or the storage array. It updates the latches when the status byte is the target. One cycle later it reports whether the byte is acknowledged, and a refused byte gets no acknowledge. The latches move only on exact bit patterns written with every other bit zero. The register latch can only be opened after the general latch. Alarm generation and the serial protocol are outside this block.

Top module: `srw_status_reg`

## Requirements
- R1: After reset the status byte reads 01h (only the power-fail flag, bit 0, is set, with the backup and alarm inputs low) and the acknowledge output is 0.
- R2: Writing 02h to the status address sets the general latch (bit 1) and clears the register latch (bit 2). Writing 00h there clears both latches.
- R3: Writing 06h to the status address sets the register latch only while the general latch is already 1. With the general latch at 0 it changes nothing. The register latch is never 1 while the general latch is 0.
- R4: Any value written to the status address other than 00h, 02h or 06h (for example 03h, 04h, 07h, 82h, FFh) leaves both latches unchanged. Writes to other addresses never change the latches.
- R5: A write to the storage array (any address that is neither the status address nor inside the control window) is acknowledged in the following cycle if and only if the general latch was 1.
- R6: A write inside the control window (default 10h to 3Eh) is acknowledged in the following cycle if and only if both latches were 1.
- R7: The power-fail flag (bit 0) clears on the first acknowledged control-window write and stays clear until reset. Refused control writes, array writes and status writes leave it set.
- R8: A write to the status address (default 3Fh) is always acknowledged in the following cycle, whatever its value. With no write request the acknowledge is 0.
- R9: Bit 7 follows the backup-supply input through a two-stage synchronizer, reaching the new value on the second rising clock edge after the change. No write can alter it.
- R10: Bits 6 and 5 show the alarm-1 and alarm-0 inputs one clock edge after they change. Bits 4 and 3 always read 0. No write alters any of these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle byte write request |
| wr_addr | input | ADDR_W | Target address of the byte |
| wr_data | input | 8 | Data byte |
| on_backup | input | 1 | High while running from the backup supply (asynchronous) |
| alarm_in | input | 2 | Alarm flags; bit 1 is alarm 1, bit 0 is alarm 0 |
| wr_ack | output | 1 | Acknowledge for the byte written in the previous cycle |
| status_q | output | 8 | Current status byte |

## Verification
The hardest state to reach is a control-window write that is refused because the latches were opened in the wrong order. The stimulus writes the register-latch pattern while the general latch is closed, then opens the general latch, and then attempts a control write. That write must still be refused, and the power-fail flag must survive it. A second hard case is a general-latch write that arrives while the register latch is open. The bench reaches it by rewriting 02h after the full 02h/06h sequence and checks that a control write is refused while array writes still pass.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_BAT  = 7;
  localparam int unsigned BIT_AL1  = 6;
  localparam int unsigned BIT_AL0  = 5;
  localparam int unsigned BIT_RWEL = 2;
  localparam int unsigned BIT_WEL  = 1;
  localparam int unsigned BIT_PF   = 0;

  localparam logic [STAT_W-1:0] PAT_CLEAR    = 8'h00;
  localparam logic [STAT_W-1:0] PAT_OPEN_GEN = 8'h02;
  localparam logic [STAT_W-1:0] PAT_OPEN_REG = 8'h06;

  typedef enum logic [1:0] {
    RGN_STATUS = 2'd0,
    RGN_CTRL   = 2'd1,
    RGN_ARRAY  = 2'd2
  } srw_region_e;
endpackage

// File: rtl/srw_rst_sync.sv
module srw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srw_sync.sv
module srw_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      always_comb stage_d = d;
    end else begin : g_rest
      always_comb stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/srw_addr_dec.sv
module srw_addr_dec
  import srw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3F,
  parameter logic [ADDR_W-1:0] CTRL_LO   = 'h10,
  parameter logic [ADDR_W-1:0] CTRL_HI   = 'h3E
) (
  input  logic [ADDR_W-1:0] addr,
  output srw_region_e       region
);
  logic in_ctrl;

  always_comb begin
    in_ctrl = (addr >= CTRL_LO) && (addr <= CTRL_HI);
    if (addr == STAT_ADDR)  region = RGN_STATUS;
    else if (in_ctrl)       region = RGN_CTRL;
    else                    region = RGN_ARRAY;
  end
endmodule

// File: rtl/srw_latch_ctl.sv
module srw_latch_ctl
  import srw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  srw_region_e       region,
  input  logic [STAT_W-1:0] wr_data,
  output logic              gen_open,
  output logic              reg_open,
  output logic              pwr_fail,
  output logic              ack
);
  logic gen_q, gen_d;
  logic reg_q, reg_d;
  logic pf_q, pf_d;
  logic ack_q, ack_d;
  logic stat_hit, ctrl_hit, allow;
  logic upd_en;

  always_comb begin
    stat_hit = wr_en && (region == RGN_STATUS);
    ctrl_hit = wr_en && (region == RGN_CTRL);
    gen_d    = gen_q;
    reg_d    = reg_q;
    if (stat_hit) begin
      unique case (wr_data)
        PAT_CLEAR: begin
          gen_d = 1'b0;
          reg_d = 1'b0;
        end
        PAT_OPEN_GEN: begin
          gen_d = 1'b1;
          reg_d = 1'b0;
        end
        PAT_OPEN_REG: begin
          if (gen_q) reg_d = 1'b1;
        end
        default: ;
      endcase
    end
    unique case (region)
      RGN_STATUS: allow = 1'b1;
      RGN_CTRL:   allow = gen_q && reg_q;
      default:    allow = gen_q;
    endcase
    ack_d  = wr_en && allow;
    pf_d   = pf_q && !(ctrl_hit && gen_q && reg_q);
    upd_en = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
      reg_q <= 1'b0;
      pf_q  <= 1'b1;
    end else if (upd_en) begin
      gen_q <= gen_d;
      reg_q <= reg_d;
      pf_q  <= pf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign gen_open = gen_q;
  assign reg_open = reg_q;
  assign pwr_fail = pf_q;
  assign ack      = ack_q;
endmodule

// File: rtl/srw_status_reg.sv
module srw_status_reg
  import srw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3F,
  parameter logic [ADDR_W-1:0] CTRL_LO   = 'h10,
  parameter logic [ADDR_W-1:0] CTRL_HI   = 'h3E,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_ALARMS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              on_backup,
  input  logic [1:0]        alarm_in,
  output logic              wr_ack,
  output logic [7:0]        status_q
);
  logic                  rst_sync_n;
  srw_region_e           region;
  logic                  gen_open, reg_open, pwr_fail;
  logic                  bat_s;
  logic [NUM_ALARMS-1:0] al_q, al_d;
  logic [STAT_W-1:0]     stat_c;

  srw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_bat_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (on_backup),
    .q     (bat_s)
  );

  srw_addr_dec #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .CTRL_LO   (CTRL_LO),
    .CTRL_HI   (CTRL_HI)
  ) u_dec (
    .addr   (wr_addr),
    .region (region)
  );

  srw_latch_ctl u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .region   (region),
    .wr_data  (wr_data),
    .gen_open (gen_open),
    .reg_open (reg_open),
    .pwr_fail (pwr_fail),
    .ack      (wr_ack)
  );

  always_comb al_d = alarm_in;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) al_q <= '0;
    else             al_q <= al_d;
  end

  always_comb begin
    stat_c           = '0;
    stat_c[BIT_BAT]  = bat_s;
    stat_c[BIT_AL1]  = al_q[1];
    stat_c[BIT_AL0]  = al_q[0];
    stat_c[BIT_RWEL] = reg_open;
    stat_c[BIT_WEL]  = gen_open;
    stat_c[BIT_PF]   = pwr_fail;
  end

  assign status_q = stat_c;
endmodule

// File: rtl/srw_status_chk.sv
module srw_status_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3F,
  parameter logic [ADDR_W-1:0] CTRL_LO   = 'h10,
  parameter logic [ADDR_W-1:0] CTRL_HI   = 'h3E
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_ack,
  input logic [7:0]        status_q
);
  logic is_stat, is_ctrl, is_arr;
  always_comb begin
    is_stat = wr_en && (wr_addr == STAT_ADDR);
    is_ctrl = wr_en && !is_stat && (wr_addr >= CTRL_LO) && (wr_addr <= CTRL_HI);
    is_arr  = wr_en && !is_stat && !is_ctrl;
  end

  AST_GEN_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_stat && (wr_data == 8'h02) |=> status_q[1] && !status_q[2]); // R2
  AST_REG_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_q[2] |-> status_q[1]); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !is_stat |=> $stable(status_q[2:1])); // R4
  AST_ARRAY_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_arr |=> wr_ack == $past(status_q[1])); // R5
  AST_CTRL_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_ctrl |=> wr_ack == $past(status_q[1] && status_q[2])); // R6
  AST_PF_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !status_q[0] |=> !status_q[0]); // R7
  AST_STAT_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_stat |=> wr_ack); // R8
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> !wr_ack); // R8
endmodule

bind srw_status_reg srw_status_chk #(
  .ADDR_W    (ADDR_W),
  .STAT_ADDR (STAT_ADDR),
  .CTRL_LO   (CTRL_LO),
  .CTRL_HI   (CTRL_HI)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_ack     (wr_ack),
  .status_q   (status_q)
);

// File: tb/srw_status_reg_tb_top.sv
`timescale 1ns/1ps
module srw_status_reg_tb_top;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] A_STAT = 16'h003F;
  localparam logic [AW-1:0] A_CTRL = 16'h0020;
  localparam logic [AW-1:0] A_CLO  = 16'h0010;
  localparam logic [AW-1:0] A_CHI  = 16'h003E;
  localparam logic [AW-1:0] A_ARR  = 16'h0100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          on_backup;
  logic [1:0]    alarm_in;
  logic          wr_ack;
  logic [7:0]    status_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  srw_status_reg dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .on_backup (on_backup),
    .alarm_in  (alarm_in),
    .wr_ack    (wr_ack),
    .status_q  (status_q)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Drive one write, return at the negedge after the capturing edge.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(status_q, 8'h01, "R1 reset status");
    chk({7'd0, wr_ack}, 8'h00, "R1 reset ack");
  endtask

  task automatic t_gen_latch();
    do_reset();
    wr(A_STAT, 8'h02);
    chk(status_q, 8'h03, "R2 02h opens general latch");
    chk({7'd0, wr_ack}, 8'h01, "R8 status write acked");
    wr(A_STAT, 8'h06);
    chk(status_q, 8'h07, "R3 06h opens register latch");
    wr(A_STAT, 8'h02);
    chk(status_q, 8'h03, "R2 02h closes register latch");
    wr(A_STAT, 8'h06);
    wr(A_STAT, 8'h00);
    chk(status_q, 8'h01, "R2 00h closes both latches");
    @(negedge clk);
    chk({7'd0, wr_ack}, 8'h00, "R8 idle no ack");
  endtask

  task automatic t_order();
    do_reset();
    wr(A_STAT, 8'h06);
    chk(status_q, 8'h01, "R3 06h ignored while general closed");
    wr(A_STAT, 8'h02);
    wr(A_CTRL, 8'h55);
    chk({7'd0, wr_ack}, 8'h00, "R6 ctrl refused with only general latch");
    chk(status_q, 8'h03, "R7 power-fail kept on refused ctrl write");
    wr(A_ARR, 8'h55);
    chk({7'd0, wr_ack}, 8'h01, "R5 array acked with general latch");
    chk(status_q, 8'h03, "R7 power-fail kept on array write");
  endtask

  task automatic t_bad_patterns();
    logic [7:0] pats [6] = '{8'h03, 8'h04, 8'h07, 8'h82, 8'hFF, 8'h0E};
    do_reset();
    wr(A_STAT, 8'h02);
    for (int i = 0; i < 6; i++) begin
      wr(A_STAT, pats[i]);
      chk(status_q, 8'h03, "R4 odd pattern leaves latches");
    end
    wr(A_STAT, 8'h06);
    wr(A_STAT, 8'h01);
    chk(status_q, 8'h07, "R4 01h leaves both latches open");
    wr(A_ARR, 8'h00);
    chk(status_q, 8'h07, "R4 array write of 00h leaves latches");
  endtask

  task automatic t_array_gate();
    do_reset();
    wr(A_ARR, 8'hA5);
    chk({7'd0, wr_ack}, 8'h00, "R5 array refused with latches closed");
    wr(16'h0000, 8'hA5);
    chk({7'd0, wr_ack}, 8'h00, "R5 array addr 0 refused");
    wr(A_CTRL, 8'hA5);
    chk({7'd0, wr_ack}, 8'h00, "R6 ctrl refused with latches closed");
    chk(status_q, 8'h01, "R7 power-fail kept");
    wr(A_STAT, 8'hFF);
    chk({7'd0, wr_ack}, 8'h01, "R8 status write acked with odd value");
  endtask

  task automatic t_ctrl_gate();
    do_reset();
    wr(A_STAT, 8'h02);
    wr(A_STAT, 8'h06);
    wr(A_CLO, 8'h12);
    chk({7'd0, wr_ack}, 8'h01, "R6 ctrl low edge acked with both latches");
    chk(status_q, 8'h06, "R7 power-fail cleared by ctrl write");
    wr(A_CHI, 8'h12);
    chk({7'd0, wr_ack}, 8'h01, "R6 ctrl high edge acked");
    wr(A_STAT, 8'h02);
    wr(A_CTRL, 8'h12);
    chk({7'd0, wr_ack}, 8'h00, "R6 ctrl refused after register latch closed");
    wr(A_ARR, 8'h12);
    chk({7'd0, wr_ack}, 8'h01, "R5 array still acked");
    wr(A_STAT, 8'h00);
    chk(status_q, 8'h00, "R7 power-fail stays clear");
  endtask

  task automatic t_status_bits();
    do_reset();
    @(negedge clk);
    on_backup = 1'b1;
    @(negedge clk);
    chk(status_q, 8'h01, "R9 backup not yet visible after one edge");
    @(negedge clk);
    chk(status_q, 8'h81, "R9 backup visible after two edges");
    alarm_in = 2'b10;
    @(negedge clk);
    chk(status_q, 8'hC1, "R10 alarm 1 on bit 6");
    alarm_in = 2'b01;
    @(negedge clk);
    chk(status_q, 8'hA1, "R10 alarm 0 on bit 5");
    wr(A_STAT, 8'h00);
    chk(status_q, 8'hA1, "R9 R10 read-only bits survive write of 00h");
    alarm_in = 2'b00; on_backup = 1'b0;
    repeat (3) @(negedge clk);
    wr(A_STAT, 8'hF8);
    chk(status_q, 8'h01, "R10 write of F8h sets no read-only bit");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    on_backup = 1'b0; alarm_in = 2'b00;
    t_reset();
    t_gen_latch();
    t_order();
    t_bad_patterns();
    t_array_gate();
    t_ctrl_gate();
    t_status_bits();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule